// File: doc/BRIEF.md
# Synchronous DRAM Data-Mask and Clock-Suspend Pipeline

This block models the timing of the data pins of a synchronous DRAM. It does not generate addresses or decode commands. Each cycle it takes one beat of read data from the array, with a valid flag. It registers that beat onto the output value and output-enable pins. Each cycle it also takes a write beat and turns it into a write strobe to the array. The per-beat mask input acts with different delays on the two directions. On a read, a mask sampled on a clock edge blanks the output two active clocks later. On a write, the mask blocks the write in the same cycle.

The clock-enable input can freeze the internal clock. A low clock-enable sampled on one edge stops the next edge, and a high sampled on a later edge lets the edge after it run again. While the clock is frozen, the read outputs keep their values, the mask delay line does not move, and no write strobe is produced. The ongoing transfer is therefore stretched, not lost. The data width and both latencies are parameters. The defaults are 4 bits, a read-mask delay of 2 and a suspend delay of 1.

Top module: `dq_mask_suspend`

## Requirements
- R1: While reset is asserted and after its release, before any clock edge, `dq_oe` is 0, `dq_out` is all zeros and `arr_we` is 0.
- R2: On an active edge where `rd_valid` is 1, `dq_out` takes `rd_data` after that edge. `dq_oe` goes to 1 unless the read mask blanks that beat.
- R3: On an active edge where `rd_valid` is 0, `dq_oe` goes to 0 and `dq_out` keeps its previous value, whatever `dqm` is.
- R4: A 1 on `dqm` sampled at active edge k forces `dq_oe` to 0 for the beat registered at active edge k+2. Beats registered at edges k+1 and k+3 are not affected by it.
- R5: While the clock is running, `arr_we` equals `wr_en` AND NOT `dqm` in the same cycle, with no register in between. `arr_wdata` always equals `wr_data`.
- R6: An edge is active exactly when `cke` was 1 at the previous edge. Reset counts as `cke` = 1, so suspend takes effect one edge after `cke` falls and ends one edge after it rises.
- R7: At a suspended edge, `dq_oe` and `dq_out` keep their values. During the cycle that follows a low `cke` sample, `arr_we` is 0 even when `wr_en` is 1 and `dqm` is 0.
- R8: The read-mask delay line advances only on active edges, so the two-clock delay of R4 counts active edges only.
- R9: `DATA_W` sets the width of `rd_data`, `wr_data`, `dq_out` and `arr_wdata`, with a default of 4. An illegal width or latency stops elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable, 0 requests suspend |
| dqm | input | 1 | Data mask, for both read and write |
| rd_valid | input | 1 | Read beat present this cycle |
| rd_data | input | DATA_W | Read beat from the array |
| wr_en | input | 1 | Write beat present this cycle |
| wr_data | input | DATA_W | Write beat from the pins |
| dq_oe | output | 1 | Data pin output enable |
| dq_out | output | DATA_W | Data pin output value |
| arr_we | output | 1 | Write strobe to the array |
| arr_wdata | output | DATA_W | Write data to the array |

## Verification
The bench raises `dqm` for one beat inside a continuous read and checks that exactly the second following beat is blanked. A design with the delay off by one would blank a neighbouring beat instead. A second test raises the mask just before a suspend. There the blanked beat has to appear two active edges later, after the freeze. A delay line that kept shifting while frozen would lose the blank entirely or blank the wrong beat. The suspend tests toggle `cke` with writes pending and check that the strobe drops exactly one cycle after the fall and returns one cycle after the rise. A design with no entry delay, or one that gated writes through a register, fails those samples. Masked writes are also checked against unmasked ones, and data hold is checked after an invalid read beat.

// File: rtl/dq_mask_suspend_pkg.sv
package dq_mask_suspend_pkg;

   typedef enum logic {
      CLK_HELD = 1'b0,
      CLK_RUN  = 1'b1
   } clk_state_e;

   localparam int unsigned MAX_LATENCY = 8;

   function automatic logic is_running(input clk_state_e s);
      return s == CLK_RUN;
   endfunction

endpackage

// File: rtl/dq_suspend_ctl.sv
module dq_suspend_ctl
   import dq_mask_suspend_pkg::*;
#(
   parameter int unsigned CSL = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cke,
   output logic run
);

   clk_state_e state;

   generate
      if (CSL == 0) begin : g_direct
         assign state = cke ? CLK_RUN : CLK_HELD;
      end else if (CSL == 1) begin : g_one
         clk_state_e st_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q <= CLK_RUN;
            else        st_q <= cke ? CLK_RUN : CLK_HELD;
         end
         assign state = st_q;
      end else begin : g_chain
         logic [CSL-1:0] sr_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr_q <= '1;
            else        sr_q <= {sr_q[CSL-2:0], cke};
         end
         assign state = sr_q[CSL-1] ? CLK_RUN : CLK_HELD;
      end
   endgenerate

   assign run = is_running(state);

endmodule

// File: rtl/dq_mask_delay.sv
module dq_mask_delay #(
   parameter int unsigned LAT = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic mask_in,
   output logic mask_late
);

   generate
      if (LAT == 0) begin : g_none
         assign mask_late = mask_in;
      end else if (LAT == 1) begin : g_one
         logic m_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   m_q <= 1'b0;
            else if (run) m_q <= mask_in;
         end
         assign mask_late = m_q;
      end else begin : g_chain
         logic [LAT-1:0] m_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   m_q <= '0;
            else if (run) m_q <= {m_q[LAT-2:0], mask_in};
         end
         assign mask_late = m_q[LAT-1];
      end
   endgenerate

endmodule

// File: rtl/dq_read_stage.sv
module dq_read_stage #(
   parameter int unsigned DATA_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              blank,
   input  logic              rd_valid,
   input  logic [DATA_W-1:0] rd_data,
   output logic              oe,
   output logic [DATA_W-1:0] dout
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oe   <= 1'b0;
         dout <= '0;
      end else if (run) begin
         oe <= rd_valid & ~blank;
         if (rd_valid) dout <= rd_data;
      end
   end

endmodule

// File: rtl/dq_write_gate.sv
module dq_write_gate #(
   parameter int unsigned DATA_W = 4
) (
   input  logic              run,
   input  logic              mask,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic              we,
   output logic [DATA_W-1:0] wdata
);

   always_comb begin
      we    = run & wr_en & ~mask;
      wdata = wr_data;
   end

endmodule

// File: rtl/dq_mask_suspend.sv
module dq_mask_suspend
   import dq_mask_suspend_pkg::*;
#(
   parameter int unsigned DATA_W      = 4,
   parameter int unsigned RD_MASK_LAT = 2,
   parameter int unsigned SUSPEND_LAT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cke,
   input  logic              dqm,
   input  logic              rd_valid,
   input  logic [DATA_W-1:0] rd_data,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic              dq_oe,
   output logic [DATA_W-1:0] dq_out,
   output logic              arr_we,
   output logic [DATA_W-1:0] arr_wdata
);

   // R9: parameter legality
   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("dq_mask_suspend: DATA_W must be at least 1");
      end
      if (RD_MASK_LAT > MAX_LATENCY) begin : g_bad_rd_lat
         $error("dq_mask_suspend: RD_MASK_LAT exceeds MAX_LATENCY");
      end
      if (SUSPEND_LAT > MAX_LATENCY) begin : g_bad_susp_lat
         $error("dq_mask_suspend: SUSPEND_LAT exceeds MAX_LATENCY");
      end
   endgenerate

   logic run;        // R6: internal clock running this cycle
   logic blank_rd;   // R4/R8: delayed read mask

   dq_suspend_ctl #(.CSL(SUSPEND_LAT)) u_susp (
      .clk   (clk),
      .rst_n (rst_n),
      .cke   (cke),
      .run   (run)
   );

   dq_mask_delay #(.LAT(RD_MASK_LAT)) u_mask (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .mask_in   (dqm),
      .mask_late (blank_rd)
   );

   dq_read_stage #(.DATA_W(DATA_W)) u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .blank    (blank_rd),
      .rd_valid (rd_valid),
      .rd_data  (rd_data),
      .oe       (dq_oe),
      .dout     (dq_out)
   );

   dq_write_gate #(.DATA_W(DATA_W)) u_wr (
      .run     (run),
      .mask    (dqm),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .we      (arr_we),
      .wdata   (arr_wdata)
   );

endmodule

// File: rtl/dq_mask_suspend_chk.sv
module dq_mask_suspend_chk #(
   parameter int unsigned DATA_W      = 4,
   parameter int unsigned RD_MASK_LAT = 2,
   parameter int unsigned SUSPEND_LAT = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cke,
   input logic              dqm,
   input logic              rd_valid,
   input logic [DATA_W-1:0] rd_data,
   input logic              wr_en,
   input logic              dq_oe,
   input logic [DATA_W-1:0] dq_out,
   input logic              arr_we
);

   logic [2:0] age;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         age <= '0;
      else if (age != 3'd5) age <= age + 3'd1;
   end

   // R5: a mask or an idle write never strobes
   a_r5_mask_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
      (dqm || !wr_en) |-> !arr_we);

   generate
      if (SUSPEND_LAT == 1) begin : g_susp1
         // R7: no strobe in the cycle after a low clock-enable sample
         a_r7_no_strobe_suspended: assert property (@(posedge clk) disable iff (!rst_n)
            (age >= 3'd1 && !$past(cke)) |-> !arr_we);
         // R7: outputs frozen across a suspended edge
         a_r7_hold_outputs: assert property (@(posedge clk) disable iff (!rst_n)
            (age >= 3'd1 && !$past(cke)) |=> ($stable(dq_oe) && $stable(dq_out)));
         // R3: no valid beat, no output enable
         a_r3_oe_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
            (age >= 3'd2 && $past(cke, 2) && !$past(rd_valid)) |-> !dq_oe);
         // R2: data follows the beat of the last active edge
         a_r2_data_follows: assert property (@(posedge clk) disable iff (!rst_n)
            (age >= 3'd2 && $past(cke, 2) && $past(rd_valid)) |-> (dq_out == $past(rd_data)));
         if (RD_MASK_LAT == 2) begin : g_lat2
            // R4: mask two active edges earlier blanks the output
            a_r4_read_blank: assert property (@(posedge clk) disable iff (!rst_n)
               (age >= 3'd4 && $past(dqm, 3) && $past(cke, 4) && $past(cke, 3) && $past(cke, 2))
               |-> !dq_oe);
         end
      end
   endgenerate

endmodule

bind dq_mask_suspend dq_mask_suspend_chk #(
   .DATA_W      (DATA_W),
   .RD_MASK_LAT (RD_MASK_LAT),
   .SUSPEND_LAT (SUSPEND_LAT)
) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cke      (cke),
   .dqm      (dqm),
   .rd_valid (rd_valid),
   .rd_data  (rd_data),
   .wr_en    (wr_en),
   .dq_oe    (dq_oe),
   .dq_out   (dq_out),
   .arr_we   (arr_we)
);

// File: tb/test_dq_mask_suspend.sv
module test_dq_mask_suspend;

   localparam int unsigned W = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cke = 1'b1;
   logic         dqm = 1'b0;
   logic         rd_valid = 1'b0;
   logic [W-1:0] rd_data = '0;
   logic         wr_en = 1'b0;
   logic [W-1:0] wr_data = '0;
   logic         dq_oe;
   logic [W-1:0] dq_out;
   logic         arr_we;
   logic [W-1:0] arr_wdata;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #5 clk = ~clk;

   dq_mask_suspend #(.DATA_W(W)) i_dq_mask_suspend (
      .clk       (clk),
      .rst_n     (rst_n),
      .cke       (cke),
      .dqm       (dqm),
      .rd_valid  (rd_valid),
      .rd_data   (rd_data),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .dq_oe     (dq_oe),
      .dq_out    (dq_out),
      .arr_we    (arr_we),
      .arr_wdata (arr_wdata)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic drv_rd(input logic v, input logic [W-1:0] d, input logic m, input logic k);
      rd_valid = v; rd_data = d; dqm = m; cke = k;
   endtask

   task automatic t_reset();
      step(); step();
      chk("R1 oe in reset", dq_oe, 0);
      chk("R1 out in reset", dq_out, 0);
      rst_n = 1'b1;
      #1;
      chk("R1 oe after release", dq_oe, 0);
      chk("R1 out after release", dq_out, 0);
      chk("R1 no strobe", arr_we, 0);
   endtask

   task automatic t_read_basic();
      drv_rd(1, 4'h5, 0, 1); step();
      chk("R2 oe", dq_oe, 1);
      chk("R2 data", dq_out, 5);
      drv_rd(0, 4'h9, 1, 1); step();
      chk("R3 oe low on invalid", dq_oe, 0);
      chk("R3 data held", dq_out, 5);
      drv_rd(0, 4'h0, 0, 1); step(); step();
   endtask

   task automatic t_read_mask_lat();
      drv_rd(1, 4'hA, 1, 1); step();
      chk("R4 beat k", dq_oe, 1);
      drv_rd(1, 4'hB, 0, 1); step();
      chk("R4 beat k+1", dq_oe, 1);
      drv_rd(1, 4'hC, 0, 1); step();
      chk("R4 beat k+2 blanked", dq_oe, 0);
      chk("R4 data still moves", dq_out, 12);
      drv_rd(1, 4'hD, 0, 1); step();
      chk("R4 beat k+3", dq_oe, 1);
      drv_rd(0, 4'h0, 0, 1); step(); step();
   endtask

   task automatic t_mask_freeze();
      drv_rd(1, 4'h1, 1, 1); step();
      chk("R8 first beat", dq_oe, 1);
      drv_rd(1, 4'h2, 0, 0); step();
      chk("R8 second beat oe", dq_oe, 1);
      chk("R8 second beat data", dq_out, 2);
      drv_rd(1, 4'h3, 0, 0); step();
      chk("R7 hold oe", dq_oe, 1);
      chk("R7 hold data", dq_out, 2);
      drv_rd(1, 4'h4, 0, 1); step();
      chk("R7 hold data again", dq_out, 2);
      drv_rd(1, 4'h5, 0, 1); step();
      chk("R8 blank after freeze", dq_oe, 0);
      chk("R8 data after freeze", dq_out, 5);
      drv_rd(1, 4'h6, 0, 1); step();
      chk("R8 oe back", dq_oe, 1);
      drv_rd(0, 4'h0, 0, 1); step(); step();
   endtask

   task automatic t_write_mask();
      wr_en = 1; dqm = 0; wr_data = 4'h7; #1;
      chk("R5 strobe", arr_we, 1);
      chk("R5 data", arr_wdata, 7);
      dqm = 1; #1;
      chk("R5 masked", arr_we, 0);
      wr_en = 0; dqm = 0; wr_data = 4'h3; #1;
      chk("R5 idle", arr_we, 0);
      chk("R5 data pass", arr_wdata, 3);
      step();
   endtask

   task automatic t_write_suspend();
      wr_en = 1; dqm = 0; wr_data = 4'hE; cke = 1; step();
      chk("R6 strobe before suspend", arr_we, 1);
      cke = 0; #1;
      chk("R6 entry delayed", arr_we, 1);
      step();
      chk("R7 no strobe suspended", arr_we, 0);
      step();
      chk("R7 still suspended", arr_we, 0);
      cke = 1; #1;
      chk("R6 exit delayed", arr_we, 0);
      step();
      chk("R6 strobe resumes", arr_we, 1);
      wr_en = 0; step();
   endtask

   initial begin
      t_reset();
      t_read_basic();
      t_read_mask_lat();
      t_mask_freeze();
      t_write_mask();
      t_write_suspend();
      chk("R9 width", $bits(dq_out), 4);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule